// File: doc/BRIEF.md
# Write-Back Direct-Mapped Data Cache Controller

This block is a direct-mapped data cache placed between a processor load/store port and a lower-level memory. Each line keeps a valid flag, a modified flag, a tag and a block of several words. A request address is cut into a byte field, a word-select field, a line index and a tag. A request that hits completes in the cycle it is presented. Stores update only the cache and mark the line modified. Memory sees a modified block only when that block is replaced.

On a miss the controller raises `cpu_stall`. If the victim line is modified, its block address and words are copied into a small write buffer. The controller then asks memory for the new block, collects it one word per beat, installs the tag and valid flag, and lets the held request finish as a hit. A store miss follows the same path and merges the store data after the fill. The write buffer drains to memory on its own port, so a dirty eviction costs the processor nothing extra unless every buffer entry is occupied. A miss whose block is still waiting in the buffer issues no memory read until that entry has drained.

Back-pressure rules. The processor must hold `cpu_req_valid`, `cpu_req_write`, `cpu_req_addr` and `cpu_req_wdata` stable while `cpu_stall` is high. A request is taken at a rising edge where `cpu_req_valid` is high and `cpu_stall` is low. The memory read-request, read-data and write channels use valid/ready. A transfer happens at a rising edge where both are high. A source keeps valid high and its payload stable until the transfer is taken.

Top module: `wb_dcache`

## Requirements
- R1: With the default parameters (4 words of 32 bits per line, 32 lines), address bits [1:0] select the byte (ignored), bits [3:2] select the word, bits [8:4] give the line index and bits [31:9] form the tag. Distinct indices occupy distinct lines.
- R2: A request hits when the indexed line is valid and its tag equals the address tag. The hit is taken with `cpu_stall` low in the cycle it is presented. With no request present, `cpu_stall` is low.
- R3: After reset every line is invalid, and the first access to any index misses. After reset no memory request and no response is pending.
- R4: A store that hits updates the cache word and produces no memory write. Later loads of that word return the stored value.
- R5: A store miss fetches the whole block and then merges the store word. The other words of the block keep their memory values.
- R6: A miss that replaces a clean line writes nothing to memory. A miss that replaces a modified line sends exactly that block's words and address to memory through the write buffer.
- R7: On a miss, `cpu_stall` stays high and one read request is issued with a block-aligned address (bits [3:0] zero). The fill ends only after all 4 words have arrived. The held request then completes with the correct data.
- R8: The write buffer drains one word per beat, in ascending word order from the block base address. It holds valid, address and data while ready is low.
- R9: When the write buffer is full and a miss must evict a modified line, the processor stays stalled and no read request is issued until an entry frees.
- R10: A miss to a block still held in the write buffer issues no memory read until that entry has fully drained, so the returned data is the modified data.
- R11: With the default configuration and an empty cache, byte addresses 1000, 1004, 1008, 2548, 2552, 2556 give miss, hit, miss, miss, hit, hit.
- R12: `cpu_rsp_valid` pulses for one cycle, one cycle after a load is taken, carrying the word. A taken store produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Byte address of the request |
| cpu_req_wdata | input | WORD_W | Store data |
| cpu_stall | output | 1 | Request cannot be taken this cycle |
| cpu_rsp_valid | output | 1 | Load data valid |
| cpu_rsp_rdata | output | WORD_W | Load data |
| mem_rd_req_valid | output | 1 | Block read request valid |
| mem_rd_req_ready | input | 1 | Memory accepts the read request |
| mem_rd_req_addr | output | ADDR_W | Block-aligned read address |
| mem_rd_data_valid | input | 1 | Fill word valid |
| mem_rd_data_ready | output | 1 | Controller accepts a fill word |
| mem_rd_data | input | WORD_W | Fill word, block order from word 0 |
| mem_wr_valid | output | 1 | Write-back word valid |
| mem_wr_ready | input | 1 | Memory accepts the write-back word |
| mem_wr_addr | output | ADDR_W | Byte address of the write-back word |
| mem_wr_data | output | WORD_W | Write-back word |

## Verification
The hardest situations to reach from the ports are a full write buffer and a miss to a block that is still queued for write-back. In normal traffic the buffer drains within a few cycles of each eviction. The bench therefore holds the memory write channel not-ready for a long stretch. It first dirties several lines, then forces conflicting misses so that evicted blocks pile up. While writes are blocked, it checks that the processor stays stalled and that no read request appears. It then releases the channel and checks the data that comes back. Full sweeps over all 32 indices cover cold misses, hits, store hits and dirty evictions. Expected hit/miss results and memory contents come from an arithmetic model of tags and memory kept in the bench.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_REQ   = 2'd2,
    ST_FILL  = 2'd3
  } wbc_state_e;
endpackage

// File: rtl/wbc_line_store.sv
module wbc_line_store #(
  parameter int LINES  = 32,
  parameter int TAG_W  = 23,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WSEL_W = $clog2(WORDS),
  localparam int LINE_W = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              st_en,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic [WSEL_W-1:0] st_wsel,
  input  logic [WORD_W-1:0] st_data,
  input  logic              fl_en,
  input  logic [IDX_W-1:0]  fl_idx,
  input  logic [WSEL_W-1:0] fl_wsel,
  input  logic [WORD_W-1:0] fl_data,
  input  logic              inst_en,
  input  logic [IDX_W-1:0]  inst_idx,
  input  logic [TAG_W-1:0]  inst_tag
);
  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [WORD_W-1:0] data_q [LINES][WORDS];

  // state flags: valid set on install, modified set by store hits, cleared on install
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (inst_en) begin
        valid_q[inst_idx] <= 1'b1;
        dirty_q[inst_idx] <= 1'b0;
      end
      if (st_en) dirty_q[st_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (inst_en) tag_q[inst_idx] <= inst_tag;
  end

  always_ff @(posedge clk) begin
    if (st_en) data_q[st_idx][st_wsel] <= st_data;
    if (fl_en) data_q[fl_idx][fl_wsel] <= fl_data;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign rd_line[w*WORD_W +: WORD_W] = data_q[rd_idx][w];
  end
endmodule

// File: rtl/wbc_write_buffer.sv
module wbc_write_buffer #(
  parameter int DEPTH  = 2,
  parameter int BLK_W  = 28,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int LINE_W = WORD_W * WORDS,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int BYTE_W = $clog2(WORD_W / 8),
  localparam int ADDR_W = BLK_W + WSEL_W + BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic [BLK_W-1:0]  push_blk,
  input  logic [LINE_W-1:0] push_line,
  output logic              full,
  input  logic [BLK_W-1:0]  look_blk,
  output logic              look_match,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [WORD_W-1:0] out_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]  ent_v;
  logic [BLK_W-1:0]  ent_blk  [DEPTH];
  logic [LINE_W-1:0] ent_line [DEPTH];
  logic [PTR_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WSEL_W-1:0] beat_q;
  logic [DEPTH-1:0]  hit_vec;
  logic              push_ok, beat_go, pop_done;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign push_ok  = push_en && !full;
  assign out_valid = ent_v[head_q];
  assign beat_go  = out_valid && out_ready;
  assign pop_done = beat_go && (beat_q == WSEL_W'(WORDS - 1));
  assign out_addr = {ent_blk[head_q], beat_q, {BYTE_W{1'b0}}};
  assign out_data = ent_line[head_q][beat_q*WORD_W +: WORD_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v  <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      beat_q <= '0;
    end else begin
      if (push_ok) begin
        ent_v[tail_q] <= 1'b1;
        tail_q        <= step(tail_q);
      end
      if (pop_done) begin
        ent_v[head_q] <= 1'b0;
        head_q        <= step(head_q);
      end
      if (beat_go) beat_q <= pop_done ? '0 : beat_q + WSEL_W'(1);
      unique case ({push_ok, pop_done})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      ent_blk[tail_q]  <= push_blk;
      ent_line[tail_q] <= push_line;
    end
  end

  // any queued block matching the lookup address blocks a fill of that block
  for (genvar e = 0; e < DEPTH; e++) begin : g_match
    assign hit_vec[e] = ent_v[e] && (ent_blk[e] == look_blk);
  end
  assign look_match = |hit_vec;
endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
  import wbc_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int WSEL_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              hit,
  input  logic              vic_dirty,
  input  logic              wb_full,
  input  logic              wb_match,
  input  logic              rd_req_ready,
  input  logic              rd_data_valid,
  output logic              stall,
  output logic              accept,
  output logic              push_en,
  output logic              rd_req_valid,
  output logic              rd_data_ready,
  output logic              fill_en,
  output logic [WSEL_W-1:0] fill_wsel,
  output logic              install_en
);
  wbc_state_e        state_q, state_d;
  logic [WSEL_W-1:0] beat_q;

  always_comb begin
    state_d       = state_q;
    push_en       = 1'b0;
    rd_req_valid  = 1'b0;
    rd_data_ready = 1'b0;
    fill_en       = 1'b0;
    install_en    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid && !hit) state_d = vic_dirty ? ST_EVICT : ST_REQ;
      end
      ST_EVICT: begin
        if (!wb_full) begin
          push_en = 1'b1;
          state_d = ST_REQ;
        end
      end
      ST_REQ: begin
        rd_req_valid = !wb_match;
        if (!wb_match && rd_req_ready) state_d = ST_FILL;
      end
      ST_FILL: begin
        rd_data_ready = 1'b1;
        if (rd_data_valid) begin
          fill_en = 1'b1;
          if (beat_q == WSEL_W'(WORDS - 1)) begin
            install_en = 1'b1;
            state_d    = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_REQ) beat_q <= '0;
      else if (fill_en)      beat_q <= beat_q + WSEL_W'(1);
    end
  end

  assign accept    = req_valid && (state_q == ST_IDLE) && hit;
  assign stall     = req_valid && !accept;
  assign fill_wsel = beat_q;
endmodule

// File: rtl/wb_dcache.sv
module wb_dcache #(
  parameter int ADDR_W   = 32,
  parameter int WORD_W   = 32,
  parameter int WORDS    = 4,
  parameter int LINES    = 32,
  parameter int WB_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [WORD_W-1:0] cpu_req_wdata,
  output logic              cpu_stall,
  output logic              cpu_rsp_valid,
  output logic [WORD_W-1:0] cpu_rsp_rdata,
  output logic              mem_rd_req_valid,
  input  logic              mem_rd_req_ready,
  output logic [ADDR_W-1:0] mem_rd_req_addr,
  input  logic              mem_rd_data_valid,
  output logic              mem_rd_data_ready,
  input  logic [WORD_W-1:0] mem_rd_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [WORD_W-1:0] mem_wr_data
);
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int OFF_W  = BYTE_W + WSEL_W;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int LINE_W = WORD_W * WORDS;

  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [WSEL_W-1:0] a_wsel;
  logic [BYTE_W-1:0] unused_byte_bits;

  assign a_tag            = cpu_req_addr[ADDR_W-1 -: TAG_W];
  assign a_idx            = cpu_req_addr[OFF_W +: IDX_W];
  assign a_wsel           = cpu_req_addr[BYTE_W +: WSEL_W];
  assign unused_byte_bits = cpu_req_addr[BYTE_W-1:0];

  logic              ln_valid, ln_dirty;
  logic [TAG_W-1:0]  ln_tag;
  logic [LINE_W-1:0] ln_data;
  logic              hit, vic_dirty;
  logic              accept, push_en, fill_en, install_en;
  logic [WSEL_W-1:0] fill_wsel;
  logic              wb_full, wb_hazard;

  assign hit       = ln_valid && (ln_tag == a_tag);
  assign vic_dirty = ln_valid && ln_dirty;

  wbc_line_store #(
    .LINES(LINES), .TAG_W(TAG_W), .WORD_W(WORD_W), .WORDS(WORDS)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (a_idx),
    .rd_valid (ln_valid),
    .rd_dirty (ln_dirty),
    .rd_tag   (ln_tag),
    .rd_line  (ln_data),
    .st_en    (accept && cpu_req_write),
    .st_idx   (a_idx),
    .st_wsel  (a_wsel),
    .st_data  (cpu_req_wdata),
    .fl_en    (fill_en),
    .fl_idx   (a_idx),
    .fl_wsel  (fill_wsel),
    .fl_data  (mem_rd_data),
    .inst_en  (install_en),
    .inst_idx (a_idx),
    .inst_tag (a_tag)
  );

  wbc_write_buffer #(
    .DEPTH(WB_DEPTH), .BLK_W(BLK_W), .WORD_W(WORD_W), .WORDS(WORDS)
  ) u_wbuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_en    (push_en),
    .push_blk   ({ln_tag, a_idx}),
    .push_line  (ln_data),
    .full       (wb_full),
    .look_blk   (cpu_req_addr[ADDR_W-1:OFF_W]),
    .look_match (wb_hazard),
    .out_valid  (mem_wr_valid),
    .out_ready  (mem_wr_ready),
    .out_addr   (mem_wr_addr),
    .out_data   (mem_wr_data)
  );

  wbc_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (cpu_req_valid),
    .hit           (hit),
    .vic_dirty     (vic_dirty),
    .wb_full       (wb_full),
    .wb_match      (wb_hazard),
    .rd_req_ready  (mem_rd_req_ready),
    .rd_data_valid (mem_rd_data_valid),
    .stall         (cpu_stall),
    .accept        (accept),
    .push_en       (push_en),
    .rd_req_valid  (mem_rd_req_valid),
    .rd_data_ready (mem_rd_data_ready),
    .fill_en       (fill_en),
    .fill_wsel     (fill_wsel),
    .install_en    (install_en)
  );

  assign mem_rd_req_addr = {cpu_req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) cpu_rsp_valid <= 1'b0;
    else        cpu_rsp_valid <= accept && !cpu_req_write;
  end

  always_ff @(posedge clk) begin
    if (accept && !cpu_req_write) cpu_rsp_rdata <= ln_data[a_wsel*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int BYTE_W = $clog2(WORD_W / 8),
  localparam int WSEL_W = $clog2(WORDS),
  localparam int OFF_W  = BYTE_W + WSEL_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_write,
  input logic              cpu_stall,
  input logic              cpu_rsp_valid,
  input logic              mem_rd_req_valid,
  input logic              mem_rd_req_ready,
  input logic [ADDR_W-1:0] mem_rd_req_addr,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [WORD_W-1:0] mem_wr_data,
  input logic              wb_hazard
);
  assert_idle_nostall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req_valid |-> !cpu_stall);

  assert_rdreq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req_valid && !mem_rd_req_ready) |=> (mem_rd_req_valid && $stable(mem_rd_req_addr)));

  assert_rdreq_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req_valid |-> (mem_rd_req_addr[OFF_W-1:0] == '0));

  assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  assert_wr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && mem_wr_ready && (mem_wr_addr[OFF_W-1:BYTE_W] != WSEL_W'(WORDS - 1))) |=>
      (mem_wr_valid && (mem_wr_addr == $past(mem_wr_addr) + ADDR_W'(WORD_W / 8))));

  assert_no_stale_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req_valid |-> !wb_hazard);

  assert_rsp_after_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> $past(cpu_req_valid && !cpu_req_write && !cpu_stall));
endmodule

bind wb_dcache wbc_checker #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .cpu_req_valid    (cpu_req_valid),
  .cpu_req_write    (cpu_req_write),
  .cpu_stall        (cpu_stall),
  .cpu_rsp_valid    (cpu_rsp_valid),
  .mem_rd_req_valid (mem_rd_req_valid),
  .mem_rd_req_ready (mem_rd_req_ready),
  .mem_rd_req_addr  (mem_rd_req_addr),
  .mem_wr_valid     (mem_wr_valid),
  .mem_wr_ready     (mem_wr_ready),
  .mem_wr_addr      (mem_wr_addr),
  .mem_wr_data      (mem_wr_data),
  .wb_hazard        (wb_hazard)
);

// File: tb/wb_dcache_tb.sv
module wb_dcache_tb;
  localparam int MEMW = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [31:0] cpu_req_addr = '0, cpu_req_wdata = '0;
  logic        cpu_stall, cpu_rsp_valid;
  logic [31:0] cpu_rsp_rdata;
  logic        mem_rd_req_valid, mem_rd_req_ready = 1'b0;
  logic [31:0] mem_rd_req_addr;
  logic        mem_rd_data_valid = 1'b0, mem_rd_data_ready;
  logic [31:0] mem_rd_data = '0;
  logic        mem_wr_valid, mem_wr_ready = 1'b0;
  logic [31:0] mem_wr_addr, mem_wr_data;

  always #10 clk = ~clk;

  wb_dcache u_dut (.*);

  logic [31:0] mem  [MEMW];
  logic [31:0] refm [MEMW];
  logic        m_valid [32];
  logic [22:0] m_tag   [32];
  int total = 0, bad = 0, wr_beats = 0;
  bit wr_hold = 1'b0, done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory read side: request then 4 data beats
  initial begin
    bit busy = 0, a_fire = 0, d_fire = 0;
    int beat = 0, cyc = 0;
    logic [11:0] base = '0, lat = '0;
    forever begin
      @(negedge clk);
      if (d_fire) begin beat++; if (beat == 4) busy = 0; end
      if (a_fire) begin busy = 1; beat = 0; base = lat; end
      cyc++;
      mem_rd_req_ready = !busy && cyc[0];
      a_fire = mem_rd_req_valid && mem_rd_req_ready;
      if (a_fire) begin
        lat = mem_rd_req_addr[13:2];
        chk(mem_rd_req_addr[3:0] == 4'd0, "R7", "fill address aligned",
            mem_rd_req_addr[3:0], 0);
      end
      mem_rd_data_valid = busy && (cyc % 4 != 2);
      mem_rd_data = mem[base + 12'(beat)];
      d_fire = mem_rd_data_valid && mem_rd_data_ready;
    end
  end

  // memory write side
  initial begin
    int cyc = 0, wbeat = 0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_wr_ready = !wr_hold && (cyc % 3 != 1);
      if (mem_wr_valid && mem_wr_ready) begin
        chk(int'(mem_wr_addr[3:2]) == wbeat, "R8", "write-back word order",
            mem_wr_addr[3:2], wbeat);
        mem[mem_wr_addr[13:2]] = mem_wr_data;
        wbeat = (wbeat + 1) % 4;
        wr_beats++;
      end
    end
  end

  // exp: -1 use tag model, 0 miss, 1 hit
  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d,
                        input int exp, input string req);
    logic [4:0]  idx = a[8:4];
    logic [22:0] tg  = a[31:9];
    bit          eh  = (exp < 0) ? (m_valid[idx] && m_tag[idx] == tg) : (exp == 1);
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = d;
    #1;
    chk(cpu_stall == !eh, req, $sformatf("hit/miss at %0h", a), !cpu_stall, eh);
    while (cpu_stall) begin @(negedge clk); #1; end
    @(negedge clk);
    cpu_req_valid = 0;
    #1;
    if (wr) begin
      refm[a[13:2]] = d;
      chk(!cpu_rsp_valid, "R12", "no response to store", cpu_rsp_valid, 0);
    end else begin
      chk(cpu_rsp_valid && cpu_rsp_rdata == refm[a[13:2]], req,
          $sformatf("load data at %0h", a), cpu_rsp_rdata, refm[a[13:2]]);
    end
    m_valid[idx] = 1; m_tag[idx] = tg;
  endtask

  task automatic wait_drain();
    int quiet = 0;
    while (quiet < 8) begin
      @(negedge clk); #1;
      if (mem_wr_valid) quiet = 0; else quiet++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int beats0;
    for (int i = 0; i < MEMW; i++) begin
      mem[i]  = 32'h5A00_0000 | (i * 7);
      refm[i] = mem[i];
    end
    for (int i = 0; i < 32; i++) begin m_valid[i] = 0; m_tag[i] = '0; end
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    chk(!cpu_stall && !cpu_rsp_valid && !mem_rd_req_valid && !mem_wr_valid, "R3",
        "idle after reset", {cpu_stall, cpu_rsp_valid, mem_rd_req_valid, mem_wr_valid}, 0);

    // R11 reference sequence on an empty cache
    access(0, 1000, 0, 0, "R11");
    access(0, 1004, 0, 1, "R11");
    access(0, 1008, 0, 0, "R11");
    access(0, 2548, 0, 0, "R11");
    access(0, 2552, 0, 1, "R11");
    access(0, 2556, 0, 1, "R11");

    // R1 / R3: cold sweep of every index, then all hit (R2)
    for (int i = 0; i < 32; i++) access(0, 32'h1000 + i*16 + (i % 4)*4, 0, -1, "R1");
    for (int i = 0; i < 32; i++) access(0, 32'h1000 + i*16 + ((i+1) % 4)*4, 0, 1, "R2");

    // R4: store hits leave memory untouched
    beats0 = wr_beats;
    for (int i = 0; i < 32; i++) access(1, 32'h1000 + i*16 + (i % 4)*4, 32'hD000_0000 | i, 1, "R4");
    repeat (10) @(negedge clk);
    chk(wr_beats == beats0, "R4", "no memory writes on store hits", wr_beats, beats0);
    for (int i = 0; i < 32; i++) access(0, 32'h1000 + i*16 + (i % 4)*4, 0, 1, "R4");

    // R6: conflicting misses evict every modified line
    for (int i = 0; i < 32; i++) access(0, 32'h2000 + i*16, 0, 0, "R6");
    wait_drain();
    chk(wr_beats == beats0 + 128, "R6", "write-back beat count", wr_beats, beats0 + 128);
    for (int i = 0; i < 32 * 4; i++)
      chk(mem[(32'h1000 >> 2) + i] == refm[(32'h1000 >> 2) + i], "R6", "evicted block in memory",
          mem[(32'h1000 >> 2) + i], refm[(32'h1000 >> 2) + i]);

    // R6: clean victims are dropped
    beats0 = wr_beats;
    for (int i = 0; i < 8; i++) access(0, 32'h3000 + i*16, 0, 0, "R6");
    repeat (10) @(negedge clk);
    chk(wr_beats == beats0, "R6", "clean eviction writes nothing", wr_beats, beats0);

    // R5: store miss allocates and merges
    access(1, 32'h0814, 32'hCAFE_0001, 0, "R5");
    access(0, 32'h0810, 0, 1, "R5");
    access(0, 32'h0814, 0, 1, "R5");
    access(0, 32'h0818, 0, 1, "R5");
    access(0, 32'h081C, 0, 1, "R5");

    // R10: miss to a block still queued for write-back
    wr_hold = 1;
    access(1, 32'h0028, 32'hBEEF_0010, -1, "R10");
    access(0, 32'h0420, 0, 0, "R10");
    fork
      begin
        repeat (25) @(negedge clk); #1;
        chk(cpu_stall && !mem_rd_req_valid, "R10", "read held while block queued",
            {cpu_stall, mem_rd_req_valid}, 2'b10);
        wr_hold = 0;
      end
    join_none
    access(0, 32'h0028, 0, 0, "R10");
    wait_drain();

    // R9: full write buffer stalls a dirty eviction
    wr_hold = 1;
    access(1, 32'h0044, 32'hA000_0004, -1, "R9");
    access(1, 32'h0054, 32'hA000_0005, -1, "R9");
    access(1, 32'h0064, 32'hA000_0006, -1, "R9");
    access(0, 32'h0440, 0, 0, "R9");
    access(0, 32'h0450, 0, 0, "R9");
    fork
      begin
        repeat (25) @(negedge clk); #1;
        chk(cpu_stall && !mem_rd_req_valid && mem_wr_valid, "R9", "stall while buffer full",
            {cpu_stall, mem_rd_req_valid, mem_wr_valid}, 3'b101);
        wr_hold = 0;
      end
    join_none
    access(0, 32'h0460, 0, 0, "R9");
    wait_drain();
    for (int b = 4; b <= 6; b++)
      for (int w = 0; w < 4; w++)
        chk(mem[b*4 + w] == refm[b*4 + w], "R9", "drained block contents",
            mem[b*4 + w], refm[b*4 + w]);
    access(0, 32'h0044, 0, 0, "R9");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule